// File: doc/BRIEF.md
# Card Bus Clock Divider with Gated Start and Stop

This block derives the clock for a memory-card bus from the system clock. The division has two stages. The first is a prescaler that is either bypassed or divides by twice its programmed value. The second is a small integer stage that divides by one more than its field. The rate is held in one register, written as a single word: the prescaler sits in the upper field and the divider in the low four bits.

The clock is switched on and off through three single-cycle strobes: start, stop and soft reset. Start and stop act only at the boundary between periods, so the card never sees a shortened high pulse. Soft reset takes effect at once. It puts the rate back to divide-by-2, stops the clock and emits a one-cycle pulse that the rest of the host can use.

A running flag shows whether the card clock is currently being driven. It is meant for bit 8 of the host's status word. The card clock is a registered output in the system clock domain. Its half periods are whole system-clock cycles.

Top module: `card_clk_gen`

## Requirements
- R1: The rate word holds the prescaler p in bits 15:4 and the divider d in bits 3:0. While the clock runs, each card clock period lasts (d+1)*M system cycles, where M is 1 when p is 0 and 2p otherwise. A d of 0 acts as d = 1.
- R2: Each period begins with its high phase. The high phase lasts floor(N/2) cycles of the period length N and the low phase lasts the rest, so an odd N (prescaler bypassed) is one cycle longer low than high.
- R3: A start strobe enables the clock and a stop strobe disables it. When both arrive in the same cycle, stop wins and the clock stays off.
- R4: After a start, the clock begins only at a period boundary. The running flag rises in the same cycle as the first rising edge, and that first high phase has full length.
- R5: After a stop, the current period completes with a full high phase. The running flag falls while the clock is low, and the clock stays low afterwards.
- R6: The card clock is never high while the running flag is low.
- R7: A soft reset strobe, in the next cycle, drives the clock low, clears the running flag and raises the soft-reset pulse for exactly one cycle. It also restores divide-by-2 with no prescaling. A start given in the same cycle is kept and takes effect at the next boundary; without a start the clock stays off.
- R8: The sequence reset, then reset with start, then eight starts leaves the clock running at divide-by-2 (one cycle high, one low).
- R9: A rate write drives the clock low in the next cycle and restarts both stages, so the following periods have exactly the new length. The running flag is not changed.
- R10: After the synchronous reset the clock is low, the running flag and the soft-reset pulse are 0, and the rate is divide-by-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_we | input | 1 | Rate word write strobe |
| rate_wdata | input | 16 | Rate word: prescaler in 15:4, divider in 3:0 |
| stop_req | input | 1 | Stop strobe |
| start_req | input | 1 | Start strobe |
| reset_req | input | 1 | Soft reset strobe |
| card_clk_o | output | 1 | Card bus clock |
| clk_running_o | output | 1 | Card clock is running |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
A wrong prescaler count or a wrong phase count shows up on the card clock within the first period after a rate write. It appears as a high or low phase whose length differs from the arithmetic value, so the bench sweeps every divider value against several prescalers. A wrong enable or run state shows up at the boundary where start or stop applies. It appears as a truncated first or last pulse, or as a running flag out of step with the clock edges, and this is visible at most one period after the strobe. Soft-reset faults show up in the very next cycle, on the pulse, the flag and the restored divide-by-2.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int PRE_W_DEF = 12;
  localparam int DIV_W_DEF = 4;
  localparam logic [15:0] RATE_RESET_VAL = 16'h0001;
endpackage

// File: rtl/ccg_prescaler.sv
module ccg_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             restart,
  input  logic [PRE_W-1:0] term,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = !restart && (pre_q == term);

  always_ff @(posedge clk) begin
    if (restart || tick) pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ccg_phase.sv
module ccg_phase #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] k_cur,
  input  logic [CNT_W-1:0] half_cur,
  input  logic [CNT_W-1:0] k_new,
  output logic             wrap,
  output logic             hi_n
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign wrap = tick && (cnt_q == k_cur - 1'b1);

  always_comb begin
    if (restart)   cnt_n = k_new - 1'b1;
    else if (wrap) cnt_n = '0;
    else if (tick) cnt_n = cnt_q + 1'b1;
    else           cnt_n = cnt_q;
  end

  assign hi_n = !restart && (cnt_n < half_cur);

  always_ff @(posedge clk) cnt_q <= cnt_n;
endmodule

// File: rtl/ccg_gate.sv
module ccg_gate (
  input  logic clk,
  input  logic rst,
  input  logic srst,
  input  logic start_req,
  input  logic stop_req,
  input  logic wrap,
  input  logic hi_n,
  output logic card_clk_o,
  output logic running_o
);
  logic want_q, run_n;

  always_comb begin
    if (rst || srst) run_n = 1'b0;
    else if (wrap)   run_n = want_q;
    else             run_n = running_o;
  end

  always_ff @(posedge clk) begin
    if (rst)           want_q <= 1'b0;
    else if (srst)     want_q <= start_req && !stop_req;
    else if (stop_req) want_q <= 1'b0;
    else if (start_req) want_q <= 1'b1;
    running_o  <= run_n;
    card_clk_o <= run_n && hi_n;
  end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int PRE_W = PRE_W_DEF,
  parameter int DIV_W = DIV_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rate_we,
  input  logic [PRE_W+DIV_W-1:0] rate_wdata,
  input  logic                   stop_req,
  input  logic                   start_req,
  input  logic                   reset_req,
  output logic                   card_clk_o,
  output logic                   clk_running_o,
  output logic                   soft_rst_o
);
  localparam int RATE_W = PRE_W + DIV_W;
  localparam int CNT_W  = DIV_W + 2;
  localparam logic [RATE_W-1:0] RATE_DEF = RATE_W'(RATE_RESET_VAL);

  function automatic logic [CNT_W-1:0] k_of(input logic [RATE_W-1:0] r);
    logic [CNT_W-1:0] de;
    de = CNT_W'(r[DIV_W-1:0]);
    if (de == '0) de = CNT_W'(1);
    de = de + 1'b1;
    if (r[RATE_W-1:DIV_W] != '0) de = de << 1;
    return de;
  endfunction

  function automatic logic [PRE_W-1:0] term_of(input logic [RATE_W-1:0] r);
    logic [PRE_W-1:0] p;
    p = r[RATE_W-1:DIV_W];
    return (p == '0) ? '0 : p - 1'b1;
  endfunction

  logic              srst_now, restart, tick, wrap, hi_n;
  logic [RATE_W-1:0] rate_q, rate_n;
  logic [CNT_W-1:0]  k_cur, half_cur, k_new;

  assign srst_now = reset_req;
  assign restart  = rst || srst_now || rate_we;

  always_comb begin
    if (rst || srst_now) rate_n = RATE_DEF;
    else if (rate_we)    rate_n = rate_wdata;
    else                 rate_n = rate_q;
  end

  always_ff @(posedge clk) begin
    rate_q     <= rate_n;
    soft_rst_o <= !rst && srst_now;
  end

  assign k_cur    = k_of(rate_q);
  assign half_cur = k_cur >> 1;
  assign k_new    = k_of(rate_n);

  ccg_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk(clk), .restart(restart), .term(term_of(rate_q)), .tick(tick)
  );

  ccg_phase #(.CNT_W(CNT_W)) i_phase (
    .clk(clk), .restart(restart), .tick(tick), .k_cur(k_cur),
    .half_cur(half_cur), .k_new(k_new), .wrap(wrap), .hi_n(hi_n)
  );

  ccg_gate i_gate (
    .clk(clk), .rst(rst), .srst(srst_now), .start_req(start_req),
    .stop_req(stop_req), .wrap(wrap), .hi_n(hi_n),
    .card_clk_o(card_clk_o), .running_o(clk_running_o)
  );
endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk (
  input logic clk,
  input logic rst,
  input logic rate_we,
  input logic reset_req,
  input logic card_clk_o,
  input logic clk_running_o,
  input logic soft_rst_o
);
  // R6
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    card_clk_o |-> clk_running_o);
  // R4
  start_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_running_o) |-> card_clk_o);
  // R5
  stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(clk_running_o) && !soft_rst_o) |-> !$past(card_clk_o));
  // R7
  srst_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> (soft_rst_o && !clk_running_o && !card_clk_o));
  // R9
  restart_low_chk: assert property (@(posedge clk) disable iff (rst)
    rate_we |=> !card_clk_o);
endmodule

bind card_clk_gen card_clk_gen_chk i_chk (
  .clk(clk), .rst(rst), .rate_we(rate_we), .reset_req(reset_req),
  .card_clk_o(card_clk_o), .clk_running_o(clk_running_o),
  .soft_rst_o(soft_rst_o)
);

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 190000;
  localparam int GUARD = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_we = 1'b0;
  logic [15:0] rate_wdata = '0;
  logic stop_req = 1'b0, start_req = 1'b0, reset_req = 1'b0;
  logic card_clk_o, clk_running_o, soft_rst_o;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;

  card_clk_gen i_card_clk_gen (
    .clk(clk), .rst(rst), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .stop_req(stop_req), .start_req(start_req), .reset_req(reset_req),
    .card_clk_o(card_clk_o), .clk_running_o(clk_running_o),
    .soft_rst_o(soft_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_rate(input logic [15:0] v);
    @(negedge clk); rate_we = 1'b1; rate_wdata = v;
    @(negedge clk); rate_we = 1'b0;
  endtask

  task automatic wr_ctrl(input bit rs, input bit st, input bit sp);
    @(negedge clk); reset_req = rs; start_req = st; stop_req = sp;
    @(negedge clk); reset_req = 0; start_req = 0; stop_req = 0;
  endtask

  task automatic wait_rise(output bit ok);
    logic prev;
    int n;
    prev = card_clk_o; ok = 0; n = 0;
    while (!ok && n < GUARD) begin
      @(negedge clk); n++;
      if (prev == 1'b0 && card_clk_o == 1'b1) ok = 1;
      prev = card_clk_o;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (card_clk_o == 1'b1 && hi < GUARD) begin hi++; @(negedge clk); end
    while (card_clk_o == 1'b0 && lo < GUARD) begin lo++; @(negedge clk); end
  endtask

  initial begin
    int hi, lo, n_hi, n;
    bit ok;
    int plist[6] = '{0, 1, 2, 4, 8, 64};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 card_clk", card_clk_o, 0);
    chk("R10 running", clk_running_o, 0);
    chk("R10 soft_rst", soft_rst_o, 0);
    wr_ctrl(0, 1, 0);
    wait_rise(ok); chk("R10 start seen", ok, 1);
    measure(hi, lo);
    chk("R10 default high", hi, 1); chk("R10 default low", lo, 1);

    // R1 R2 R9 sweep
    foreach (plist[i]) begin
      for (int d = 0; d < 16; d++) begin
        int de, m, nn, eh;
        de = (d == 0) ? 1 : d;
        m  = (plist[i] == 0) ? 1 : 2 * plist[i];
        nn = (de + 1) * m;
        eh = (plist[i] == 0) ? (de + 1) / 2 : nn / 2;
        wr_rate({plist[i][11:0], d[3:0]});
        chk("R9 low after rate write", card_clk_o, 0);
        chk("R9 running kept", clk_running_o, 1);
        wait_rise(ok); chk("R1 rise seen", ok, 1);
        for (int k = 0; k < 2; k++) begin
          measure(hi, lo);
          chk($sformatf("R2 high p=%0d d=%0d", plist[i], d), hi, eh);
          chk($sformatf("R1 period p=%0d d=%0d", plist[i], d), hi + lo, nn);
        end
      end
    end

    // R5 stop mid high phase; rate 0x022 -> 6 high, 6 low
    wr_rate(16'h0022);
    wait_rise(ok); measure(hi, lo);
    stop_req = 1'b1;
    hi = 0;
    while (card_clk_o == 1'b1 && hi < GUARD) begin
      hi++; @(negedge clk); stop_req = 1'b0;
    end
    stop_req = 1'b0;
    chk("R5 last high full", hi, 6);
    n_hi = 0;
    repeat (200) begin @(negedge clk); if (card_clk_o) n_hi++; end
    chk("R5 stays low", n_hi, 0);
    chk("R5 running cleared", clk_running_o, 0);

    // R3 start and stop together: stop wins
    wr_ctrl(0, 1, 1);
    n_hi = 0;
    repeat (100) begin @(negedge clk); if (card_clk_o || clk_running_o) n_hi++; end
    chk("R3 stop wins", n_hi, 0);

    // R4 start from stopped
    wr_ctrl(0, 1, 0);
    n = 0;
    while (!clk_running_o && n < GUARD) begin @(negedge clk); n++; end
    chk("R4 clock high with running", card_clk_o, 1);
    measure(hi, lo);
    chk("R4 first high full", hi, 6);
    chk("R4 first low", lo, 6);

    // R7 soft reset alone
    wr_ctrl(1, 0, 0);
    chk("R7 pulse", soft_rst_o, 1);
    chk("R7 clock low", card_clk_o, 0);
    chk("R7 running low", clk_running_o, 0);
    @(negedge clk);
    chk("R7 pulse one cycle", soft_rst_o, 0);
    n_hi = 0;
    repeat (100) begin @(negedge clk); if (card_clk_o || clk_running_o) n_hi++; end
    chk("R7 stays stopped", n_hi, 0);

    // R7 reset with start keeps start; default rate restored
    wr_ctrl(1, 1, 0);
    wait_rise(ok); chk("R7 start with reset", ok, 1);
    measure(hi, lo);
    chk("R7 divide by 2 high", hi, 1); chk("R7 divide by 2 low", lo, 1);

    // R8 full reset sequence from a slow rate
    wr_rate(16'h0043);
    wr_ctrl(1, 0, 0);
    wr_ctrl(1, 1, 0);
    for (int k = 0; k < 8; k++) wr_ctrl(0, 1, 0);
    repeat (4) @(negedge clk);
    chk("R8 running", clk_running_o, 1);
    wait_rise(ok); chk("R8 rise", ok, 1);
    measure(hi, lo);
    chk("R8 high", hi, 1); chk("R8 low", lo, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule